// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single burst request into the sequence of column addresses that a synchronous DRAM walks through, one address per clock. A request names a starting column, a burst-length code and a wrap type. The block then emits the column for each data beat, together with a valid flag and a flag on the final beat. A memory model or a controller can use it to find out which column each beat of a read or write lands on.

Fixed-length bursts stay inside an aligned block of 2, 4 or 8 columns. The low column bits count through that block in either sequential or interleaved order, and the upper bits are held. Full-page bursts step through all 512 columns and keep running until they are stopped. A new request may arrive on any clock. It replaces whatever burst is in progress.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises with no request, `valid_o` and `last_o` are 0.
- R2: When `start_i` is sampled high at a rising edge, from that edge `valid_o` is 1 and `col_o` equals the sampled `start_col_i`. This is beat 0. Each following edge advances one beat.
- R3: `bl_code_i` values 3'b000, 3'b001, 3'b010 and 3'b011 select burst lengths 1, 2, 4 and 8. With `wrap_il_i` = 0, on beat n the low log2(BL) column bits equal (start low bits + n) mod BL and the upper bits equal those of the start column.
- R4: With `wrap_il_i` = 1 and a fixed length, on beat n the low log2(BL) bits equal the start low bits XOR n and the upper bits are held.
- R5: When `bl_code_i[2]` = 1 the burst is full page. On beat n `col_o` = (start + n) mod 512, `wrap_il_i` has no effect, and beats continue until stopped.
- R6: `last_o` is 1 exactly on beat BL-1 of a fixed-length burst. It is never 1 during a full-page burst.
- R7: After the last beat of a fixed-length burst, `valid_o` is 0 on the next cycle unless a new request was sampled.
- R8: `stop_i` sampled high during a burst makes `valid_o` 0 from that edge. `stop_i` while idle leaves `valid_o` at 0.
- R9: A request sampled during a burst abandons it and starts beat 0 of the new burst at once. When `start_i` and `stop_i` are sampled high at the same edge, the request wins.
- R10: A burst of length 1 produces exactly one valid beat at the start column, with `last_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | 9 | Starting column |
| bl_code_i | input | 3 | Burst length code (bit 2 = full page) |
| wrap_il_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final one |

## Verification
Two functions can land in the same cycle: a new request and the end of the running burst. The end can come from a stop or from the final beat. The bench raises `start_i` together with `stop_i` in the middle of an 8-beat burst, and separately raises it during the final beat of a 2-beat burst. In both cases it expects beat 0 of the new burst, at the new start column, on the very next cycle, with no idle gap and no leftover beat of the old burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [1:0] {
    LEN_1 = 2'd0,
    LEN_2 = 2'd1,
    LEN_4 = 2'd2,
    LEN_8 = 2'd3
  } fixed_len_e;

  typedef struct packed {
    logic       full_page;
    logic       interleave;
    fixed_len_e len;
  } burst_mode_t;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             wrap_il_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output burst_mode_t      mode_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q, base_q, len_mask;
  burst_mode_t      mode_q;

  assign len_mask = ~({COL_W{1'b1}} << mode_q.len);
  assign last_o   = active_q && !mode_q.full_page && (beat_q == len_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mode_q   <= '0;
    end else if (start_i) begin
      active_q            <= 1'b1;
      beat_q              <= '0;
      base_q              <= start_col_i;
      mode_q.full_page    <= bl_code_i[2];
      mode_q.interleave   <= wrap_il_i;
      mode_q.len          <= fixed_len_e'(bl_code_i[1:0]);
    end else if (active_q) begin
      if (stop_i || last_o) active_q <= 1'b0;
      else                  beat_q   <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  burst_mode_t      mode_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] wrap_mask, seq_col, il_col, pick;

  // full page wraps over the whole row, fixed lengths inside an aligned block
  assign wrap_mask = mode_i.full_page ? {COL_W{1'b1}}
                                      : ~({COL_W{1'b1}} << mode_i.len);
  assign seq_col   = base_i + beat_i;
  assign il_col    = base_i ^ beat_i;
  assign pick      = (mode_i.interleave && !mode_i.full_page) ? il_col : seq_col;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = wrap_mask[i] ? pick[i] : base_i[i];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             wrap_il_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] beat, base;
  burst_mode_t      mode;

  burst_ctl #(.COL_W(COL_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .start_col_i(start_col_i),
    .bl_code_i  (bl_code_i),
    .wrap_il_i  (wrap_il_i),
    .stop_i     (stop_i),
    .active_o   (valid_o),
    .last_o     (last_o),
    .beat_o     (beat),
    .base_o     (base),
    .mode_o     (mode)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i(base),
    .beat_i(beat),
    .mode_i(mode),
    .col_o (col_o)
  );
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_code_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic fp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fp_q <= 1'b0;
    else if (start_i) fp_q <= bl_code_i[2];
  end

  a_r2_start_beat0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  a_r6_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  a_r6_no_last_full_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fp_q) |-> !last_o);

  a_r5_full_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fp_q && !start_i && !stop_i) |=>
      (valid_o && col_o == $past(col_o) + 1'b1));

  a_r7_end_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  a_r8_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !valid_o);
endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .start_col_i(start_col_i),
  .bl_code_i  (bl_code_i),
  .stop_i     (stop_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] scol = '0;
  logic [2:0] code = '0;
  logic       il = 1'b0;
  logic       stop = 1'b0;
  logic [8:0] col;
  logic       valid, last;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .bl_code_i(code), .wrap_il_i(il), .stop_i(stop),
    .col_o(col), .valid_o(valid), .last_o(last)
  );

  function automatic logic [8:0] exp_col(input logic [8:0] b, input int n,
                                         input logic [2:0] c, input logic w);
    logic [8:0] m, nn;
    nn = 9'(n);
    if (c[2]) return b + nn;
    m = 9'((1 << c[1:0]) - 1);
    if (w) return (b & ~m) | ((b ^ nn) & m);
    return (b & ~m) | ((b + nn) & m);
  endfunction

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic issue(input logic [8:0] b, input logic [2:0] c, input logic w);
    @(negedge clk);
    start = 1'b1; scol = b; code = c; il = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk(9'(valid), 9'd0, "R1 valid in reset");
    chk(9'(last), 9'd0, "R1 last in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(9'(valid), 9'd0, "R1 valid after reset");
    chk(9'(last), 9'd0, "R1 last after reset");
  endtask

  task automatic t_fixed(input logic [8:0] b, input logic [2:0] c, input logic w,
                         input string req);
    int bl = 1 << c[1:0];
    issue(b, c, w);
    for (int n = 0; n < bl; n++) begin
      chk(9'(valid), 9'd1, {req, " valid"});
      chk(col, exp_col(b, n, c, w), {req, " col"});
      chk(9'(last), 9'(n == bl - 1), "R6 last position");
      @(negedge clk);
    end
    chk(9'(valid), 9'd0, "R7 idle after last");
  endtask

  task automatic t_full_page;
    issue(9'h1FC, 3'b100, 1'b1);
    for (int n = 0; n < 7; n++) begin
      chk(col, exp_col(9'h1FC, n, 3'b100, 1'b0), "R5 full page col");
      chk(9'(last), 9'd0, "R6 no last in full page");
      if (n == 6) stop = 1'b1;
      @(negedge clk);
    end
    stop = 1'b0;
    chk(9'(valid), 9'd0, "R8 stop ends burst");
  endtask

  task automatic t_stop_idle;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(9'(valid), 9'd0, "R8 stop while idle");
  endtask

  task automatic t_restart;
    issue(9'h010, 3'b011, 1'b0);
    chk(col, 9'h010, "R2 beat0");
    @(negedge clk);
    chk(col, 9'h011, "R3 beat1");
    start = 1'b1; stop = 1'b1; scol = 9'h0A3; code = 3'b010; il = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    for (int n = 0; n < 4; n++) begin
      chk(9'(valid), 9'd1, "R9 start beats stop");
      chk(col, exp_col(9'h0A3, n, 3'b010, 1'b1), "R9 restart col");
      @(negedge clk);
    end
    chk(9'(valid), 9'd0, "R7 idle after restart");
  endtask

  task automatic t_back_to_back;
    issue(9'h005, 3'b001, 1'b0);
    chk(col, 9'h005, "R3 bl2 beat0");
    @(negedge clk);
    chk(col, 9'h004, "R3 bl2 wrap");
    chk(9'(last), 9'd1, "R6 bl2 last");
    start = 1'b1; scol = 9'h040; code = 3'b000; il = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(9'(valid), 9'd1, "R9 seamless start");
    chk(col, 9'h040, "R10 single beat col");
    chk(9'(last), 9'd1, "R10 single beat last");
    @(negedge clk);
    chk(9'(valid), 9'd0, "R10 only one beat");
  endtask

  initial begin
    t_reset();
    t_fixed(9'h1F5, 3'b001, 1'b0, "R3 bl2");
    t_fixed(9'h1F5, 3'b010, 1'b0, "R3 bl4");
    t_fixed(9'h0AE, 3'b011, 1'b0, "R3 bl8");
    t_fixed(9'h0AE, 3'b011, 1'b1, "R4 bl8");
    t_fixed(9'h122, 3'b010, 1'b1, "R4 bl4");
    t_fixed(9'h133, 3'b000, 1'b1, "R10 bl1");
    t_full_page();
    t_stop_idle();
    t_restart();
    t_back_to_back();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule